// File: doc/BRIEF.md
# Route Trial Sequencer

This block runs the outer rip-up-and-reroute loop of a self-routing switch fabric. Software or a loader fills an internal net table, one entry per net, holding a source node, a sink node and a fanout count. After a start pulse the controller treats every loaded net as unrouted. It then works in passes. In each pass it visits every net that was unrouted when the pass began, in ascending index order, and asks the fabric to search for a path. If a path exists it orders an allocation. If none exists it chooses, starting from a pseudo-random index, a routed net that is not protected, and orders the fabric to tear that net up and give its path to the current net. The torn-up net rejoins the unrouted set in the next pass.

The loop ends when no unrouted net is left, which is success, or when the number of completed passes reaches a programmable limit while nets are still unrouted, which is failure. A net whose fanout is above a fixed threshold is never torn up, because rerouting it would cost much more work. Saturating counters record the searches, rip-ups and passes of the run, and they can be read once the run is done.

Top module: `rts_route_seq`

## Requirements
- R1: After reset the block is idle. busy_o, done_o, fail_o and cmd_valid_o are low, and all three counters read zero.
- R2: A start_i pulse in idle latches num_nets_i and rt_max_i, marks nets 0..num_nets_i-1 unrouted, clears the counters and clears done_o and fail_o. A start_i pulse while busy_o is high has no effect.
- R3: Each pass issues exactly one search command (cmd_op_o = 0) for each net that was unrouted when the pass began, in ascending net index. A net torn up during a pass is not searched until the next pass.
- R4: A search response with rsp_found_i = 1 is followed by an allocate command (cmd_op_o = 1) for the same net, and that net then counts as routed.
- R5: A search response with rsp_found_i = 0 is followed by a rip-up command (cmd_op_o = 2) for the same net, provided a legal victim exists. cmd_victim_o then names a routed, unlocked net other than the current one. After the response the victim is unrouted and the current net is routed.
- R6: A net whose fanout is above LOCK_FO (default 10) is never named as a victim. A net with fanout exactly 10 may be named.
- R7: If a search fails and no legal victim exists, no further command is issued for that net, and it stays unrouted.
- R8: The block raises done_o with fail_o = 0 when the unrouted set is empty at a pass boundary. It raises done_o with fail_o = 1 when the pass count has reached rt_max with nets still unrouted. With rt_max = 0 and at least one net, no command is issued at all.
- R9: A command holds cmd_valid_o, cmd_op_o and cmd_net_o steady until cmd_ready_i is seen. No new command is issued until rsp_valid_i acknowledges the previous one.
- R10: The search, rip-up and pass counters each stop at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Net table write enable |
| tbl_addr_i | input | IDXW | Net table write index |
| tbl_src_i | input | NODE_W | Source node of the net being written |
| tbl_sink_i | input | NODE_W | Sink node of the net being written |
| tbl_fanout_i | input | FO_W | Fanout of the net being written |
| num_nets_i | input | IDXW+1 | Number of nets to route, latched at start |
| rt_max_i | input | TRIAL_W | Maximum number of passes, latched at start |
| start_i | input | 1 | Starts a run when idle |
| cmd_valid_o | output | 1 | Fabric command valid |
| cmd_ready_i | input | 1 | Fabric accepts command |
| cmd_op_o | output | 2 | 0 search, 1 allocate, 2 rip-up and allocate |
| cmd_net_o | output | IDXW | Net being routed |
| cmd_src_o | output | NODE_W | Source node of that net |
| cmd_sink_o | output | NODE_W | Sink node of that net |
| cmd_victim_o | output | IDXW | Net to tear up (rip-up only) |
| rsp_valid_i | input | 1 | Fabric response for the accepted command |
| rsp_found_i | input | 1 | Search found a free path |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished |
| fail_o | output | 1 | Run finished with nets unrouted |
| search_cnt_o | output | CNT_W | Searches issued |
| ripup_cnt_o | output | CNT_W | Rip-ups issued |
| pass_cnt_o | output | CNT_W | Passes completed |

## Verification
Two functions can fall on the same response. The first is a rip-up that frees a victim. The second is the end of a pass that decides whether the unrouted set is empty. When the rip-up retires the last net of a pass, the victim must keep the run going rather than let it finish. A capacity-limited fabric model provokes this: it refuses searches once a fixed number of nets hold paths, so every late net in a pass steals a path. The cycle-level reference model rebuilds the unrouted set from the observed commands. It then judges that each following pass searches exactly the victims, and that done_o stays low until that set is really empty.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [1:0] {
    OP_SEARCH = 2'd0,
    OP_ALLOC  = 2'd1,
    OP_RIPUP  = 2'd2
  } rts_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_NEXT,
    ST_CMD,
    ST_WAIT
  } rts_state_e;
endpackage

// File: rtl/rts_net_table.sv
module rts_net_table #(
  parameter int NETS    = 16,
  parameter int NODE_W  = 8,
  parameter int FO_W    = 6,
  parameter int LOCK_FO = 10,
  localparam int IDXW   = $clog2(NETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDXW-1:0]   waddr_i,
  input  logic [NODE_W-1:0] src_i,
  input  logic [NODE_W-1:0] sink_i,
  input  logic [FO_W-1:0]   fanout_i,
  input  logic [IDXW-1:0]   raddr_i,
  output logic [NODE_W-1:0] src_o,
  output logic [NODE_W-1:0] sink_o,
  output logic [NETS-1:0]   locked_o
);
  logic [NODE_W-1:0] src_q  [NETS];
  logic [NODE_W-1:0] sink_q [NETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= '0;
      for (int i = 0; i < NETS; i++) begin
        src_q[i]  <= '0;
        sink_q[i] <= '0;
      end
    end else if (we_i) begin
      src_q[waddr_i]    <= src_i;
      sink_q[waddr_i]   <= sink_i;
      locked_o[waddr_i] <= (int'(fanout_i) > LOCK_FO);
    end
  end

  assign src_o  = src_q[raddr_i];
  assign sink_o = sink_q[raddr_i];
endmodule

// File: rtl/rts_victim_pick.sv
module rts_victim_pick #(
  parameter int NETS  = 16,
  localparam int IDXW = $clog2(NETS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NETS-1:0] cand_i,
  output logic            ok_o,
  output logic [IDXW-1:0] idx_o
);
  logic [15:0]     lfsr_q;
  logic [IDXW-1:0] base, j;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= 16'hACE1;
    else         lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? 16'hB400 : 16'h0);
  end

  assign base = lfsr_q[IDXW-1:0];

  // first candidate at or after a random base, wrapping
  always_comb begin
    ok_o  = 1'b0;
    idx_o = '0;
    j     = '0;
    for (int k = 0; k < NETS; k++) begin
      j = base + IDXW'(k);
      if (!ok_o && cand_i[j]) begin
        ok_o  = 1'b1;
        idx_o = j;
      end
    end
  end

  AST_PICK_IS_CAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> cand_i[idx_o]) else $error("pick not a candidate"); // R5
  AST_PICK_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_i == '0) |-> !ok_o) else $error("pick without candidates"); // R7
endmodule

// File: rtl/rts_sat_cnt.sv
module rts_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    q_o <= '0;
    else if (clr_i)                 q_o <= '0;
    else if (inc_i && q_o != '1)    q_o <= q_o + 1'b1;
  end

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o == '1) && !clr_i |=> (q_o == '1)) else $error("counter wrapped"); // R10
endmodule

// File: rtl/rts_route_seq.sv
module rts_route_seq
  import rts_pkg::*;
#(
  parameter int NETS    = 16,
  parameter int NODE_W  = 8,
  parameter int FO_W    = 6,
  parameter int LOCK_FO = 10,
  parameter int TRIAL_W = 8,
  parameter int CNT_W   = 8,
  localparam int IDXW   = $clog2(NETS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tbl_we_i,
  input  logic [IDXW-1:0]    tbl_addr_i,
  input  logic [NODE_W-1:0]  tbl_src_i,
  input  logic [NODE_W-1:0]  tbl_sink_i,
  input  logic [FO_W-1:0]    tbl_fanout_i,
  input  logic [IDXW:0]      num_nets_i,
  input  logic [TRIAL_W-1:0] rt_max_i,
  input  logic               start_i,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  output logic [1:0]         cmd_op_o,
  output logic [IDXW-1:0]    cmd_net_o,
  output logic [NODE_W-1:0]  cmd_src_o,
  output logic [NODE_W-1:0]  cmd_sink_o,
  output logic [IDXW-1:0]    cmd_victim_o,
  input  logic               rsp_valid_i,
  input  logic               rsp_found_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               fail_o,
  output logic [CNT_W-1:0]   search_cnt_o,
  output logic [CNT_W-1:0]   ripup_cnt_o,
  output logic [CNT_W-1:0]   pass_cnt_o
);
  rts_state_e         state_q;
  rts_op_e            op_q;
  logic [IDXW:0]      idx_q, num_q;
  logic [IDXW-1:0]    net;
  logic [IDXW-1:0]    victim_q;
  logic [NETS-1:0]    routed_q, pass_set_q, valid, locked, unrouted, cand;
  logic [TRIAL_W-1:0] trial_q, rtmax_q;
  logic               vic_ok;
  logic [IDXW-1:0]    vic_idx;
  logic               go, cnt_clr, hs, pass_end;
  logic [2:0]         cnt_inc;
  logic [CNT_W-1:0]   cnt_q [3];

  assign net = idx_q[IDXW-1:0];

  always_comb
    for (int i = 0; i < NETS; i++) valid[i] = (i < int'(num_q));

  assign unrouted = valid & ~routed_q;
  assign cand     = valid & routed_q & ~locked;

  rts_net_table #(.NETS(NETS), .NODE_W(NODE_W), .FO_W(FO_W), .LOCK_FO(LOCK_FO)) u_tbl (
    .clk_i, .rst_ni,
    .we_i(tbl_we_i), .waddr_i(tbl_addr_i), .src_i(tbl_src_i), .sink_i(tbl_sink_i),
    .fanout_i(tbl_fanout_i), .raddr_i(net),
    .src_o(cmd_src_o), .sink_o(cmd_sink_o), .locked_o(locked)
  );

  rts_victim_pick #(.NETS(NETS)) u_pick (
    .clk_i, .rst_ni, .cand_i(cand), .ok_o(vic_ok), .idx_o(vic_idx)
  );

  assign go       = start_i && (state_q == ST_IDLE);
  assign hs       = cmd_valid_o && cmd_ready_i;
  assign pass_end = (state_q == ST_NEXT) && (idx_q >= num_q);
  assign cnt_clr  = go;
  assign cnt_inc  = {pass_end, hs && op_q == OP_RIPUP, hs && op_q == OP_SEARCH};

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    rts_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .clr_i(cnt_clr), .inc_i(cnt_inc[g]), .q_o(cnt_q[g])
    );
  end
  assign search_cnt_o = cnt_q[0];
  assign ripup_cnt_o  = cnt_q[1];
  assign pass_cnt_o   = cnt_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_SEARCH;
      idx_q      <= '0;
      num_q      <= '0;
      victim_q   <= '0;
      routed_q   <= '0;
      pass_set_q <= '0;
      trial_q    <= '0;
      rtmax_q    <= '0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          num_q    <= (int'(num_nets_i) > NETS) ? (IDXW+1)'(NETS) : num_nets_i;
          rtmax_q  <= rt_max_i;
          routed_q <= '0;
          trial_q  <= '0;
          done_o   <= 1'b0;
          fail_o   <= 1'b0;
          state_q  <= ST_PASS;
        end
        ST_PASS: begin
          if (unrouted == '0) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (trial_q >= rtmax_q) begin
            done_o  <= 1'b1;
            fail_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            pass_set_q <= unrouted;
            idx_q      <= '0;
            state_q    <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (idx_q >= num_q) begin
            trial_q <= trial_q + 1'b1;
            state_q <= ST_PASS;
          end else if (pass_set_q[net]) begin
            op_q    <= OP_SEARCH;
            state_q <= ST_CMD;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_CMD: if (cmd_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          unique case (op_q)
            OP_SEARCH: begin
              if (rsp_found_i) begin
                op_q    <= OP_ALLOC;
                state_q <= ST_CMD;
              end else if (vic_ok) begin
                op_q     <= OP_RIPUP;
                victim_q <= vic_idx;
                state_q  <= ST_CMD;
              end else begin
                idx_q   <= idx_q + 1'b1;
                state_q <= ST_NEXT;
              end
            end
            OP_ALLOC: begin
              routed_q[net] <= 1'b1;
              idx_q         <= idx_q + 1'b1;
              state_q       <= ST_NEXT;
            end
            default: begin
              routed_q[victim_q] <= 1'b0;
              routed_q[net]      <= 1'b1;
              idx_q              <= idx_q + 1'b1;
              state_q            <= ST_NEXT;
            end
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign cmd_valid_o  = (state_q == ST_CMD);
  assign cmd_op_o     = op_q;
  assign cmd_net_o    = net;
  assign cmd_victim_o = victim_q;

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_net_o))
    else $error("command dropped"); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |=> !cmd_valid_o) else $error("command before response"); // R9
  AST_VICTIM_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_op_o == OP_RIPUP |-> !locked[cmd_victim_o] && routed_q[cmd_victim_o]
      && cmd_victim_o != cmd_net_o) else $error("illegal victim"); // R6
  AST_FAIL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o) else $error("fail without done"); // R8
  AST_TRIAL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD) |-> trial_q < rtmax_q) else $error("pass over limit"); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o) else $error("command while idle"); // R1
endmodule

// File: tb/sim_rts_route_seq.sv
module sim_rts_route_seq;
  localparam int NETS = 16, IDXW = 4, NODE_W = 8, FO_W = 6, CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_we = 0, start = 0, cmd_ready = 0, rsp_valid = 0, rsp_found = 0;
  logic [IDXW-1:0] tbl_addr = '0;
  logic [NODE_W-1:0] tbl_src = '0, tbl_sink = '0;
  logic [FO_W-1:0] tbl_fo = '0;
  logic [IDXW:0] num_nets = '0;
  logic [7:0] rt_max = '0;
  logic cmd_valid, busy, done, fail;
  logic [1:0] cmd_op;
  logic [IDXW-1:0] cmd_net, cmd_victim;
  logic [NODE_W-1:0] cmd_src, cmd_sink;
  logic [CNT_W-1:0] s_cnt, r_cnt, p_cnt;

  always #2 clk = ~clk;

  rts_route_seq u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_src_i(tbl_src), .tbl_sink_i(tbl_sink),
    .tbl_fanout_i(tbl_fo), .num_nets_i(num_nets), .rt_max_i(rt_max), .start_i(start),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op), .cmd_net_o(cmd_net),
    .cmd_src_o(cmd_src), .cmd_sink_o(cmd_sink), .cmd_victim_o(cmd_victim),
    .rsp_valid_i(rsp_valid), .rsp_found_i(rsp_found),
    .busy_o(busy), .done_o(done), .fail_o(fail),
    .search_cnt_o(s_cnt), .ripup_cnt_o(r_cnt), .pass_cnt_o(p_cnt)
  );

  int checks = 0, fails = 0, cyc = 0, cmd_no = 0;
  int fo [NETS];
  bit routed [NETS];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic load_table(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tbl_we = 1; tbl_addr = IDXW'(i);
      tbl_src = NODE_W'(i * 5 + 1); tbl_sink = NODE_W'(200 - i * 3); tbl_fo = FO_W'(fo[i]);
    end
    @(negedge clk) tbl_we = 0;
  endtask

  // wait for a command; done_o must stay low meanwhile (every-cycle compare)
  task automatic get_cmd(input int op, input int net, input bit found,
                         input int lat, output int vic, input bit poke_start);
    int t = 0;
    vic = 0;
    @(negedge clk);
    while (!cmd_valid && t < 500) begin
      if (done) chk(0, "R8 done during run", 1, 0);
      @(negedge clk); t++;
    end
    chk(cmd_valid, "R3 command expected", cmd_valid, 1);
    chk(cmd_op == 2'(op), "R3/R4/R5 op", cmd_op, op);
    chk(cmd_net == IDXW'(net), "R3 net order", cmd_net, net);
    chk(cmd_src == NODE_W'(net * 5 + 1) && cmd_sink == NODE_W'(200 - net * 3),
        "R3 src/sink", cmd_src, net * 5 + 1);
    for (int s = 0; s < cmd_no % 3; s++) @(negedge clk);
    chk(cmd_valid && cmd_net == IDXW'(net), "R9 hold under stall", cmd_valid, 1);
    vic = cmd_victim;
    cmd_ready = 1;
    @(negedge clk) cmd_ready = 0;
    cmd_no++;
    if (poke_start) start = 1;
    for (int s = 0; s < lat; s++) begin
      @(negedge clk);
      start = 0;
      chk(!cmd_valid, "R9 no command before response", cmd_valid, 0);
    end
    start = 0;
    rsp_valid = 1; rsp_found = found;
    @(negedge clk) rsp_valid = 0; rsp_found = 0;
  endtask

  // mode 0: all found; 1: capacity cap; 2: pattern
  task automatic run_case(input string name, input int n, input int rtmax, input int mode, input int cap);
    int trial = 0, searches = 0, ripups = 0, vic = 0, rc = 0;
    bit pset [NETS];
    bit exp_fail = 0, any = 0, found = 0, legal = 0;
    load_table(n);
    @(negedge clk);
    num_nets = (IDXW+1)'(n); rt_max = 8'(rtmax); start = 1;
    @(negedge clk) start = 0;
    chk(busy && !done && !fail, "R2 start clears status", done, 0);
    for (int i = 0; i < NETS; i++) routed[i] = 0;
    forever begin
      any = 0;
      for (int i = 0; i < n; i++) if (!routed[i]) any = 1;
      if (!any) begin exp_fail = 0; break; end
      if (trial >= rtmax) begin exp_fail = 1; break; end
      for (int i = 0; i < n; i++) pset[i] = !routed[i];
      for (int i = 0; i < n; i++) begin
        if (!pset[i]) continue;
        rc = 0;
        for (int k = 0; k < n; k++) rc += routed[k];
        found = (mode == 0) ? 1 : (mode == 1) ? (rc < cap) : (((searches + i * 3) % 4) != 0);
        get_cmd(0, i, found, 1 + (i % 2), vic, (mode == 1 && searches == 6));
        searches++;
        if (found) begin
          get_cmd(1, i, 0, 1, vic, 0);
          routed[i] = 1;
        end else begin
          legal = 0;
          for (int k = 0; k < n; k++) if (routed[k] && fo[k] <= 10 && k != i) legal = 1;
          if (legal) begin
            get_cmd(2, i, 0, 4 * 2, vic, 0);
            chk(vic < n && routed[vic] && vic != i, "R5 victim routed", vic, i);
            chk(fo[vic] <= 10, "R6 victim not locked", fo[vic], 10);
            routed[vic] = 0; routed[i] = 1; ripups++;
          end
        end
      end
      trial++;
    end
    for (int t = 0; t < 300 && !done; t++) begin
      @(negedge clk);
      if (cmd_valid) chk(0, "R7/R8 unexpected command", cmd_op, -1);
    end
    chk(done && !busy, {"R8 done ", name}, done, 1);
    chk(fail == exp_fail, {"R8 fail flag ", name}, fail, exp_fail);
    chk(int'(s_cnt) == sat(searches), {"R10 search count ", name}, s_cnt, sat(searches));
    chk(int'(r_cnt) == sat(ripups), {"R10 ripup count ", name}, r_cnt, sat(ripups));
    chk(int'(p_cnt) == sat(trial), {"R10 pass count ", name}, p_cnt, sat(trial));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !cmd_valid, "R1 reset outputs", busy, 0);
    chk(s_cnt == 0 && r_cnt == 0 && p_cnt == 0, "R1 reset counters", s_cnt, 0);
    rst_n = 1;
    @(negedge clk);
    // all found
    for (int i = 0; i < NETS; i++) fo[i] = 2;
    run_case("R4 easy", 8, 5, 0, 0);
    // capacity-starved fabric, two locked nets, one at the boundary; start poked mid-run (R2)
    fo[0] = 12; fo[1] = 11; fo[2] = 10;
    run_case("R5 R6 starved", 8, 100, 1, 5);
    // everything locked: no victims
    for (int i = 0; i < NETS; i++) fo[i] = 20;
    run_case("R7 locked", 6, 4, 1, 3);
    // pattern fabric, mixed locks
    for (int i = 0; i < NETS; i++) fo[i] = (i % 5 == 0) ? 15 : i % 11;
    run_case("R3 pattern", 16, 30, 2, 0);
    // zero nets and zero limit
    run_case("R8 empty", 0, 3, 0, 0);
    run_case("R8 zero limit", 4, 0, 0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule